// File: doc/BRIEF.md
# Successive-Approximation Current Trim Sequencer

This block is the digital side of a self-calibration loop for the current sources of a segmented converter. After a start pulse it walks a fixed list of cells. For each cell it runs a 6-bit successive-approximation search. It drives a segmented trim code to the calibration sub-DAC and reads a single comparator bit back after a programmable settling delay. The final code for each cell goes into a small trim store.

The list always begins with the master reference cell. The master is trimmed against a scaled reference taken from the large cells. The block then trims the 31 large cells one after the other, and after them the combined middle/fine sub-converter group, each against the trimmed master. The `ref_master` output tells the analog side which reference applies.

The trim code is split into two parts. The upper 2 bits drive thermometer units of weight 16. The lower 4 bits drive binary weights 8, 4, 2 and 1. One code step is a quarter of a converter LSB, so the full code covers a span of about ±8 LSB.

After the last cell, `done` rises. The stored codes stay readable, and do not change, until the next start.

Top module: `sar_trim_sequencer`

## Requirements
- R1: While reset is high, and on the first cycle after it, `done` is 0, `cell_sel` is 0, `ref_master` is 0, and both trim fields are 0.
- R2: An accepted start visits the cells in index order. Index 0 is the master, indices 1 to 31 are the large cells, and index 32 is the sub-converter group. `ref_master` is 0 exactly while index 0 is being trimmed and 1 for every later index.
- R3: For each cell the search tests bits 5 down to 0, one at a time. A tested bit is kept when `cmp_low` is 1 and cleared when it is 0. The stored code therefore equals the largest code whose applied value the comparator still reports as low.
- R4: The applied code c drives `trim_bin` = c[3:0`]. Bit i of `trim_therm` is 1 exactly when c[5:4] > i, so the only legal thermometer values are 000, 001, 011 and 111.
- R5: `settle_cycles` is captured at the accepted start. Its value S sets when each decision is made: the decision for a bit samples `cmp_low` at the (S+1)-th rising edge after the trim code or the cell changed.
- R6: `done` rises 33 × (6 × (S+1) + 1) rising edges after the edge that accepted start.
- R7: `rd_code` returns the stored code for `rd_addr` one cycle later. After `done`, comparator activity leaves the stored codes, the trim outputs and `done` unchanged.
- R8: A start pulse that arrives while a calibration is running is ignored. The run keeps its cell order, its timing and its results.
- R9: `done` stays high until a new start is accepted, and drops on the edge that accepts it.
- R10: A comparator that always reports low gives code 63. One that never reports low gives code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a calibration sequence; accepted only when idle or done |
| settle_cycles | input | 8 | Extra settling cycles before each comparator sample |
| cmp_low | input | 1 | Comparator result: 1 means the cell is below its reference |
| cell_sel | output | 6 | Index of the cell under trim |
| ref_master | output | 1 | 0 while the master is trimmed against the scaled reference, 1 afterwards |
| trim_therm | output | 3 | Thermometer units of weight 16 |
| trim_bin | output | 4 | Binary trim weights 8, 4, 2, 1 |
| done | output | 1 | All codes stored |
| rd_addr | input | 6 | Trim store read index |
| rd_code | output | 6 | Stored code, one cycle after `rd_addr` |

## Verification
A wrong bit pointer or a wrong keep/clear decision shows up as a wrong code for one cell. This appears at the read port only once the run has finished. A wrong settling count makes the bench's settling-aware comparator return stale answers, so every stored code shifts, and the `done` latency also moves by a fixed number of cycles per bit. A bad segment decode changes the applied value that the comparator model sees. A skipped or repeated cell index appears on `cell_sel` at the very next cycle, and so does a wrong reference phase on `ref_master`.

// File: rtl/sar_trim_pkg.sv
package sar_trim_pkg;

  // Sequencer phases: idle, searching one cell, stepping to the next cell, finished
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_TRIM = 2'd1,
    SEQ_NEXT = 2'd2,
    SEQ_DONE = 2'd3
  } seq_state_e;

endpackage

// File: rtl/trim_seg_decode.sv
module trim_seg_decode #(
  parameter int THERM_BITS = 2,
  parameter int BIN_BITS   = 4,
  localparam int CW    = THERM_BITS + BIN_BITS,
  localparam int UNITS = (1 << THERM_BITS) - 1
) (
  input  logic [CW-1:0]       code,
  output logic [UNITS-1:0]    therm,
  output logic [BIN_BITS-1:0] bin
);

  logic [THERM_BITS-1:0] hi;
  assign hi  = code[CW-1:BIN_BITS];
  assign bin = code[BIN_BITS-1:0];

  // Unit i is switched on whenever the coarse field exceeds i
  for (genvar i = 0; i < UNITS; i++) begin : g_unit
    assign therm[i] = (hi > THERM_BITS'(i));
  end

endmodule

// File: rtl/trim_store.sv
module trim_store #(
  parameter int CW    = 6,
  parameter int DEPTH = 33,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [CW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [CW-1:0] rdata
);

  logic [CW-1:0] mem [DEPTH];

  // Single write port, registered read: maps onto a simple dual-port RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/sar_step.sv
module sar_step #(
  parameter int CW       = 6,
  parameter int SETTLE_W = 8,
  localparam int BW      = $clog2(CW)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                init,
  input  logic                run,
  input  logic [SETTLE_W-1:0] settle,
  input  logic                cmp_low,
  output logic [CW-1:0]       code,
  output logic                last,
  output logic [CW-1:0]       result
);

  logic [BW-1:0]       bit_q;
  logic [SETTLE_W-1:0] wait_q;
  logic [CW-1:0]       probe;
  logic                decide;

  assign probe  = CW'(1) << bit_q;
  assign decide = run && (wait_q == settle);
  assign result = cmp_low ? code : (code & ~probe);
  assign last   = decide && (bit_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      code   <= '0;
      bit_q  <= '0;
      wait_q <= '0;
    end else if (init) begin
      code   <= CW'(1) << (CW - 1);
      bit_q  <= BW'(CW - 1);
      wait_q <= '0;
    end else if (run) begin
      if (!decide) begin
        wait_q <= wait_q + SETTLE_W'(1);
      end else begin
        wait_q <= '0;
        if (bit_q != '0) begin
          code  <= result | (CW'(1) << (bit_q - BW'(1)));
          bit_q <= bit_q - BW'(1);
        end else begin
          code <= result;
        end
      end
    end
  end

endmodule

// File: rtl/sar_trim_sequencer.sv
module sar_trim_sequencer #(
  parameter int NUM_MSB    = 31,
  parameter int THERM_BITS = 2,
  parameter int BIN_BITS   = 4,
  parameter int SETTLE_W   = 8,
  localparam int CODE_W    = THERM_BITS + BIN_BITS,
  localparam int NUM_CELLS = NUM_MSB + 2,
  localparam int ADDR_W    = $clog2(NUM_CELLS),
  localparam int UNITS     = (1 << THERM_BITS) - 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                cmp_low,
  output logic [ADDR_W-1:0]   cell_sel,
  output logic                ref_master,
  output logic [UNITS-1:0]    trim_therm,
  output logic [BIN_BITS-1:0] trim_bin,
  output logic                done,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [CODE_W-1:0]   rd_code
);
  import sar_trim_pkg::*;

  localparam logic [ADDR_W-1:0] LAST_CELL = ADDR_W'(NUM_CELLS - 1);

  seq_state_e          state;
  logic [ADDR_W-1:0]   cell_q;
  logic                phase_q;
  logic                done_q;
  logic [SETTLE_W-1:0] settle_q;

  logic                accept;
  logic                sar_init;
  logic                sar_run;
  logic                sar_last;
  logic [CODE_W-1:0]   sar_code;
  logic [CODE_W-1:0]   sar_result;

  assign accept   = start && (state == SEQ_IDLE || state == SEQ_DONE);
  assign sar_init = accept || (state == SEQ_NEXT && cell_q != LAST_CELL);
  assign sar_run  = (state == SEQ_TRIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SEQ_IDLE;
      cell_q   <= '0;
      phase_q  <= 1'b0;
      done_q   <= 1'b0;
      settle_q <= '0;
    end else begin
      unique case (state)
        SEQ_IDLE, SEQ_DONE: begin
          if (start) begin
            state    <= SEQ_TRIM;
            cell_q   <= '0;
            phase_q  <= 1'b0;
            done_q   <= 1'b0;
            settle_q <= settle_cycles;
          end
        end
        SEQ_TRIM: begin
          if (sar_last) state <= SEQ_NEXT;
        end
        SEQ_NEXT: begin
          if (cell_q == LAST_CELL) begin
            state  <= SEQ_DONE;
            done_q <= 1'b1;
          end else begin
            state   <= SEQ_TRIM;
            cell_q  <= cell_q + ADDR_W'(1);
            phase_q <= 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  sar_step #(
    .CW       (CODE_W),
    .SETTLE_W (SETTLE_W)
  ) u_step (
    .clk     (clk),
    .rst     (rst),
    .init    (sar_init),
    .run     (sar_run),
    .settle  (settle_q),
    .cmp_low (cmp_low),
    .code    (sar_code),
    .last    (sar_last),
    .result  (sar_result)
  );

  trim_seg_decode #(
    .THERM_BITS (THERM_BITS),
    .BIN_BITS   (BIN_BITS)
  ) u_dec (
    .code  (sar_code),
    .therm (trim_therm),
    .bin   (trim_bin)
  );

  trim_store #(
    .CW    (CODE_W),
    .DEPTH (NUM_CELLS)
  ) u_store (
    .clk   (clk),
    .we    (sar_last),
    .waddr (cell_q),
    .wdata (sar_result),
    .raddr (rd_addr),
    .rdata (rd_code)
  );

  assign cell_sel   = cell_q;
  assign ref_master = phase_q;
  assign done       = done_q;

endmodule

// File: rtl/sar_trim_sequencer_chk.sv
module sar_trim_sequencer_chk #(
  parameter int ADDR_W    = 6,
  parameter int UNITS     = 3,
  parameter int BIN_BITS  = 4,
  parameter int NUM_CELLS = 33
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    start,
  input logic                    done,
  input logic [ADDR_W-1:0]       cell_sel,
  input logic                    ref_master,
  input logic [UNITS-1:0]        trim_therm,
  input logic [BIN_BITS-1:0]     trim_bin,
  input sar_trim_pkg::seq_state_e state
);

  // R4
  therm_shape_chk: assert property (@(posedge clk) disable iff (rst)
    ((trim_therm & (trim_therm + UNITS'(1))) == '0));

  // R2
  cell_order_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cell_sel) |-> (cell_sel == $past(cell_sel) + ADDR_W'(1)) || (cell_sel == '0));

  // R2
  master_phase_chk: assert property (@(posedge clk) disable iff (rst)
    !ref_master |-> (cell_sel == '0));

  // R6
  done_last_cell_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (cell_sel == ADDR_W'(NUM_CELLS - 1)));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> done);

  // R9
  done_clear_chk: assert property (@(posedge clk) disable iff (rst)
    done && start |=> !done);

  // R7
  trim_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> $stable(trim_therm) && $stable(trim_bin));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (state == sar_trim_pkg::SEQ_TRIM) && start && (cell_sel != '0) |=> (cell_sel != '0));

endmodule

bind sar_trim_sequencer sar_trim_sequencer_chk #(
  .ADDR_W    (ADDR_W),
  .UNITS     (UNITS),
  .BIN_BITS  (BIN_BITS),
  .NUM_CELLS (NUM_CELLS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .done       (done),
  .cell_sel   (cell_sel),
  .ref_master (ref_master),
  .trim_therm (trim_therm),
  .trim_bin   (trim_bin),
  .state      (state)
);

// File: tb/sar_trim_sequencer_test.sv
module sar_trim_sequencer_test;
  localparam int NC = 33;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] settle = 8'd0;
  logic       cmp_low;
  logic [5:0] cell_sel;
  logic       ref_master;
  logic [2:0] trim_therm;
  logic [3:0] trim_bin;
  logic       done;
  logic [5:0] rd_addr = '0;
  logic [5:0] rd_code;

  int n_chk = 0;
  int n_fail = 0;

  sar_trim_sequencer uut (
    .clk(clk), .rst(rst), .start(start), .settle_cycles(settle), .cmp_low(cmp_low),
    .cell_sel(cell_sel), .ref_master(ref_master), .trim_therm(trim_therm),
    .trim_bin(trim_bin), .done(done), .rd_addr(rd_addr), .rd_code(rd_code)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Comparator model with settling: answers are inverted until the applied
  // code and cell have been steady for the programmed settle count (R5)
  int         target [NC];
  logic [12:0] key;
  logic [12:0] prev_key = '0;
  int          age = 0;
  int          applied;
  logic        model_cmp;
  logic        ovr_en = 1'b0;
  logic        ovr_val = 1'b0;

  assign key = {cell_sel, trim_therm, trim_bin};

  always_comb begin
    applied   = 16 * $countones(trim_therm) + int'(trim_bin);
    model_cmp = (applied <= target[cell_sel]);
    if (!((settle == 8'd0) || ((key == prev_key) && (age >= int'(settle)))))
      model_cmp = !model_cmp;
  end

  assign cmp_low = ovr_en ? ovr_val : model_cmp;

  always @(posedge clk) begin
    prev_key <= key;
    age      <= (key != prev_key) ? 1 : ((age >= 1000) ? 1000 : age + 1);
  end

  // Order / phase / segment monitor (R2, R4)
  bit tracking = 1'b0;
  int last_seen = 0;
  int order_bad = 0;
  int phase_bad = 0;
  int shape_bad = 0;

  always @(negedge clk) begin
    if (tracking) begin
      if (int'(cell_sel) != last_seen) begin
        if (int'(cell_sel) != last_seen + 1) order_bad++;
        last_seen = int'(cell_sel);
      end
      if (ref_master != (cell_sel != 6'd0)) phase_bad++;
      if (!(trim_therm inside {3'b000, 3'b001, 3'b011, 3'b111})) shape_bad++;
    end
  end

  // Scoreboard: driver pushes expected codes, monitor pops on each readback
  int    exp_q [$];
  string rd_tag = "R3";
  logic  rd_req = 1'b0;
  logic  rd_req_q = 1'b0;
  logic [5:0] rd_addr_q = '0;

  always @(posedge clk) begin
    rd_req_q  <= rd_req;
    rd_addr_q <= rd_addr;
  end

  always @(negedge clk) begin
    if (rd_req_q) begin
      if (exp_q.size() == 0) begin
        check(1'b0, {rd_tag, " scoreboard underflow"}, int'(rd_addr_q), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(int'(rd_code) == e, {rd_tag, $sformatf(" cell %0d code", rd_addr_q)}, int'(rd_code), e);
      end
    end
  end

  task automatic push_expected();
    for (int i = 0; i < NC; i++) exp_q.push_back(target[i] < 0 ? 0 : (target[i] > 63 ? 63 : target[i]));
  endtask

  task automatic read_all(input string tag);
    rd_tag = tag;
    for (int a = 0; a < NC; a++) begin
      @(negedge clk);
      rd_addr = 6'(a);
      rd_req  = 1'b1;
    end
    @(negedge clk);
    rd_req = 1'b0;
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, {tag, " scoreboard drained"}, exp_q.size(), 0);
  endtask

  task automatic run_cal(input int s, input bit mid_start, input bit after_done);
    int cycles;
    int t_exp;
    settle = 8'(s);
    t_exp  = NC * (6 * (s + 1) + 1);
    push_expected();
    order_bad = 0; phase_bad = 0; shape_bad = 0; last_seen = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    tracking = 1'b1;
    // R9: a start accepted while done was high clears it on that edge
    if (after_done) check(done == 1'b0, "R9 done cleared by new start", int'(done), 0);
    cycles = 0;
    while (!done && cycles < 20000) begin
      @(negedge clk);
      cycles++;
      if (mid_start && cycles == 50) start = 1'b1;
      if (mid_start && cycles == 51) start = 1'b0;
    end
    tracking = 1'b0;
    // R5 R6: latency depends on the latched settle count
    check(cycles == t_exp, $sformatf("R6 done latency S=%0d", s), cycles, t_exp);
    if (mid_start) check(cycles == t_exp, "R8 mid-run start ignored (latency)", cycles, t_exp);
    check(order_bad == 0 && phase_bad == 0 && last_seen == NC - 1,
          "R2 cell order and reference phase", order_bad + phase_bad, 0);
    check(shape_bad == 0, "R4 thermometer shape", shape_bad, 0);
    read_all(mid_start ? "R8" : "R3");
  endtask

  initial begin
    for (int i = 0; i < NC; i++) target[i] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(done == 1'b0, "R1 done in reset", int'(done), 0);
    check(cell_sel == 6'd0, "R1 cell_sel in reset", int'(cell_sel), 0);
    check(ref_master == 1'b0, "R1 ref_master in reset", int'(ref_master), 0);
    check(trim_therm == 3'd0, "R1 trim_therm in reset", int'(trim_therm), 0);
    check(trim_bin == 4'd0, "R1 trim_bin in reset", int'(trim_bin), 0);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && trim_therm == 3'd0, "R1 state after reset release", int'(done), 0);

    // R3 R5: spread of targets, no settling delay
    for (int i = 0; i < NC; i++) target[i] = (i * 23 + 5) % 64;
    run_cal(0, 1'b0, 1'b0);

    // R7: comparator chatter after done changes nothing
    ovr_en = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      ovr_val = ~ovr_val;
    end
    ovr_en = 1'b0;
    check(done == 1'b1, "R7 done held through comparator activity", int'(done), 1);
    push_expected();
    read_all("R7");

    // R10 R8 R5: always-low comparator gives 63, with a mid-run start pulse
    for (int i = 0; i < NC; i++) target[i] = 63;
    run_cal(3, 1'b1, 1'b1);

    // R10: never-low gives 0; master at 40
    for (int i = 0; i < NC; i++) target[i] = -1;
    target[0] = 40;
    run_cal(2, 1'b0, 1'b1);

    // R3 R5: descending targets, longer settling
    for (int i = 0; i < NC; i++) target[i] = 63 - 2 * i;
    run_cal(5, 1'b0, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule